// File: doc/BRIEF.md
# Receive Sample Phase Tuning Engine

This block finds a good receive sampling phase for a card interface. On a start request it walks a 3-bit sample-phase setting through all eight values. The walk begins one step past the current setting and ends back on it. At each phase it asks an external command/data path to run one tuning trial and records whether that trial passed. The engine generates no tuning commands and compares no patterns itself. It only takes part in the request/done/pass exchange.

After the eighth trial the engine searches the collected 8-bit pass map. It looks for the phase with the widest circular margin of passing neighbours. On success it drives that phase out, keeps it as the tuned value, and pulses `done`. If no phase passed, it pulses `fail` and leaves both the phase and the tuned value as they were. Before every trial it pulses a request that the surrounding logic set its data timeout to the maximum.

Top module: `phase_tuner`

## Requirements
- R1: After reset, `phase` and `tuned_phase` are 0, and `trial_req`, `tmo_force_max`, `done` and `fail` are low.
- R2: A sweep runs exactly eight trials. The first trial is at (phase at start + 1) mod 8, each later trial is one phase higher mod 8, and the eighth trial is at the starting phase.
- R3: `tmo_force_max` is high for exactly one cycle immediately before each rise of `trial_req`, giving eight pulses per sweep.
- R4: `trial_req` stays high, with `phase` unchanged, until a cycle in which `trial_done` is high.
- R5: The `trial_pass` value sampled with `trial_done` at phase p becomes bit p of the pass map used for selection. A high value marks the phase as passing.
- R6: First selection level: rotate the map right by i for i = 0..7 and choose the first i whose phases i-2, i-1, i, i+1 and i+2 (mod 8) all passed. This is rotated map AND 0xC7 equal to 0xC7.
- R7: When level one finds nothing, choose the first i whose phases i-1, i and i+1 passed (mask 0x83).
- R8: When level two also finds nothing, choose the lowest passing phase.
- R9: With an all-zero map, `fail` pulses for one cycle. `phase` is then back at its starting value and `tuned_phase` is unchanged.
- R10: On success, `done` pulses for one cycle, and in that same cycle `phase` and `tuned_phase` both show the selected phase. `done` and `fail` are never high together.
- R11: `start` has no effect while a sweep is running.
- R12: A `start` given in the cycle that shows `done` or `fail` is accepted. The new sweep begins one phase past the value shown in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a tuning sweep (accepted only when idle) |
| trial_req | output | 1 | Trial requested at the current phase |
| trial_done | input | 1 | Trial finished this cycle |
| trial_pass | input | 1 | Trial outcome, valid with trial_done |
| tmo_force_max | output | 1 | One-cycle request to set the data timeout to maximum |
| done | output | 1 | Success pulse |
| fail | output | 1 | No-passing-phase pulse |
| phase | output | 3 | Current sample phase |
| tuned_phase | output | 3 | Last successfully tuned phase |

## Verification
Two functions can fall in the same cycle: the completion pulse of one sweep and the acceptance of a new start. The bench chains half of its sweeps by raising `start` in the very cycle where `done` or `fail` is seen. It then judges the chained sweep by whether its first trial phase lies one above the phase just reported. All 256 pass maps are swept with varied trial latencies. Some sweeps also get a stray start in mid-sweep, which must leave the trial order and the count of eight unchanged.

// File: rtl/phase_tune_pkg.sv
package phase_tune_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PREP,
    ST_WAIT,
    ST_PICK
  } tune_st_e;

  localparam int WIN_LEVELS = 3;
endpackage

// File: rtl/tune_cand.sv
module tune_cand #(
  parameter int PHASE_W = 3,
  localparam int N = 1 << PHASE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               wr,
  input  logic [PHASE_W-1:0] idx,
  input  logic               pass,
  output logic [N-1:0]       cand
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cand <= '0;
    end else if (wr) begin
      cand[idx] <= pass;
    end
  end
endmodule

// File: rtl/tune_pick.sv
module tune_pick #(
  parameter int PHASE_W      = 3,
  parameter int WIDE_REACH   = 2,
  parameter int NARROW_REACH = 1,
  localparam int N = 1 << PHASE_W
) (
  input  logic [N-1:0]       cand,
  output logic               found,
  output logic [PHASE_W-1:0] pick
);
  import phase_tune_pkg::*;

  function automatic logic win_ok(input logic [N-1:0] v, input int c, input int r);
    logic ok;
    ok = 1'b1;
    for (int d = -r; d <= r; d++) begin
      ok = ok & v[PHASE_W'((c + d + N) % N)];
    end
    return ok;
  endfunction

  logic [WIN_LEVELS-1:0][N-1:0] hit;

  for (genvar lv = 0; lv < WIN_LEVELS; lv++) begin : g_lvl
    localparam int REACH = (lv == 0) ? WIDE_REACH : ((lv == 1) ? NARROW_REACH : 0);
    for (genvar p = 0; p < N; p++) begin : g_ph
      assign hit[lv][p] = win_ok(cand, p, REACH);
    end
  end

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int lv = 0; lv < WIN_LEVELS; lv++) begin
      for (int p = 0; p < N; p++) begin
        if (!found && hit[lv][p]) begin
          found = 1'b1;
          pick  = PHASE_W'(p);
        end
      end
    end
  end
endmodule

// File: rtl/tune_seq.sv
module tune_seq #(
  parameter int PHASE_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               trial_done,
  input  logic               found,
  input  logic [PHASE_W-1:0] pick,
  output logic               trial_req,
  output logic               tmo_force,
  output logic               cand_clr,
  output logic               cand_wr,
  output logic [PHASE_W-1:0] phase,
  output logic [PHASE_W-1:0] tuned,
  output logic               done,
  output logic               fail
);
  import phase_tune_pkg::*;

  tune_st_e           st;
  logic [PHASE_W-1:0] start_ph;

  assign trial_req = (st == ST_WAIT);
  assign tmo_force = (st == ST_PREP);
  assign cand_clr  = (st == ST_IDLE) && start;
  assign cand_wr   = (st == ST_WAIT) && trial_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      start_ph <= '0;
      phase    <= '0;
      tuned    <= '0;
      done     <= 1'b0;
      fail     <= 1'b0;
    end else begin
      done <= 1'b0;
      fail <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            start_ph <= phase;
            phase    <= phase + 1'b1;
            st       <= ST_PREP;
          end
        end
        ST_PREP: st <= ST_WAIT;
        ST_WAIT: begin
          if (trial_done) begin
            if (phase == start_ph) begin
              st <= ST_PICK;
            end else begin
              phase <= phase + 1'b1;
              st    <= ST_PREP;
            end
          end
        end
        ST_PICK: begin
          if (found) begin
            phase <= pick;
            tuned <= pick;
            done  <= 1'b1;
          end else begin
            fail <= 1'b1;
          end
          st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/phase_tuner.sv
module phase_tuner #(
  parameter int PHASE_W      = 3,
  parameter int WIDE_REACH   = 2,
  parameter int NARROW_REACH = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  output logic               trial_req,
  input  logic               trial_done,
  input  logic               trial_pass,
  output logic               tmo_force_max,
  output logic               done,
  output logic               fail,
  output logic [PHASE_W-1:0] phase,
  output logic [PHASE_W-1:0] tuned_phase
);
  localparam int N = 1 << PHASE_W;

  logic               cand_clr;
  logic               cand_wr;
  logic [N-1:0]       cand;
  logic               found;
  logic [PHASE_W-1:0] pick;

  tune_seq #(.PHASE_W(PHASE_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .trial_done (trial_done),
    .found      (found),
    .pick       (pick),
    .trial_req  (trial_req),
    .tmo_force  (tmo_force_max),
    .cand_clr   (cand_clr),
    .cand_wr    (cand_wr),
    .phase      (phase),
    .tuned      (tuned_phase),
    .done       (done),
    .fail       (fail)
  );

  tune_cand #(.PHASE_W(PHASE_W)) u_cand (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cand_clr),
    .wr    (cand_wr),
    .idx   (phase),
    .pass  (trial_pass),
    .cand  (cand)
  );

  tune_pick #(
    .PHASE_W      (PHASE_W),
    .WIDE_REACH   (WIDE_REACH),
    .NARROW_REACH (NARROW_REACH)
  ) u_pick (
    .cand  (cand),
    .found (found),
    .pick  (pick)
  );
endmodule

// File: rtl/phase_tuner_chk.sv
module phase_tuner_chk #(
  parameter int PHASE_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               trial_req,
  input logic               trial_done,
  input logic               tmo_force_max,
  input logic               done,
  input logic               fail,
  input logic [PHASE_W-1:0] phase,
  input logic [PHASE_W-1:0] tuned_phase
);
  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trial_req && !trial_done |=> trial_req);

  // R4
  phase_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trial_req && !trial_done |=> $stable(phase));

  // R3
  tmo_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trial_req) |-> $past(tmo_force_max));

  // R10
  done_fail_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_tuned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (phase == tuned_phase));

  // R9
  fail_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> $stable(tuned_phase));
endmodule

bind phase_tuner phase_tuner_chk #(.PHASE_W(PHASE_W)) u_chk (.*);

// File: tb/phase_tuner_bench.sv
module phase_tuner_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       trial_done = 1'b0;
  logic       trial_pass = 1'b0;
  logic       trial_req, tmo_force_max, done, fail;
  logic [2:0] phase, tuned_phase;

  int checks = 0;
  int errors = 0;
  int sweep_tmo = 0;
  logic prev_req = 1'b0;
  logic prev_tmo = 1'b0;
  logic [2:0] model_ph = 3'd0;
  logic [2:0] model_tuned = 3'd0;
  int cyc = 0;

  always #4 clk = ~clk;

  phase_tuner u_phase_tuner (
    .clk(clk), .rst_n(rst_n), .start(start), .trial_req(trial_req),
    .trial_done(trial_done), .trial_pass(trial_pass),
    .tmo_force_max(tmo_force_max), .done(done), .fail(fail),
    .phase(phase), .tuned_phase(tuned_phase)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R3: timeout pulse count and its position before each request
  always @(negedge clk) begin
    if (rst_n) begin
      if (tmo_force_max) sweep_tmo++;
      if (trial_req && !prev_req) chk(prev_tmo, "R3 tmo before req", prev_tmo, 1);
    end
    prev_req = trial_req;
    prev_tmo = tmo_force_max;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic void ref_pick(input logic [7:0] bm, output bit ok,
                                   output int idx, output int lvl);
    ok = 0; idx = 0; lvl = 0;
    for (int l = 0; l < 3; l++) begin
      for (int i = 0; i < 8; i++) begin
        bit all;
        int r;
        all = 1;
        r = 2 - l;
        for (int d = -r; d <= r; d++) all &= bm[(i + d + 8) % 8];
        if (!ok && all) begin ok = 1; idx = i; lvl = l; end
      end
    end
  endfunction

  task automatic sweep(input logic [7:0] bm, input int lat, input bit chain, input bit poke);
    logic [2:0] exp_ph;
    bit ok;
    int idx, lvl, w;
    string tag;
    if (!chain) repeat (2) @(negedge clk);
    exp_ph = model_ph + 3'd1;
    sweep_tmo = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 8; k++) begin
      w = 0;
      while (!trial_req && w < 20) begin @(negedge clk); w++; end
      chk(trial_req, "R2 trial request seen", trial_req, 1);
      chk(phase == exp_ph, "R2 trial phase", phase, exp_ph);
      for (int j = 0; j < lat; j++) begin
        if (poke && k == 3) start = 1'b1;  // R11 stray start while busy
        @(negedge clk);
        start = 1'b0;
        chk(trial_req && phase == exp_ph, "R4 request held", phase, exp_ph);
      end
      trial_pass = bm[phase];  // R5 pass map built from phase-indexed results
      trial_done = 1'b1;
      @(negedge clk);
      trial_done = 1'b0;
      trial_pass = 1'b0;
      exp_ph = exp_ph + 3'd1;
    end
    w = 0;
    while (!done && !fail && w < 20) begin
      chk(!trial_req, "R11 no extra trial", trial_req, 0);
      @(negedge clk); w++;
    end
    chk(sweep_tmo == 8, "R3 tmo pulses per sweep", sweep_tmo, 8);
    ref_pick(bm, ok, idx, lvl);
    if (ok) begin
      tag = (lvl == 0) ? "R6" : ((lvl == 1) ? "R7" : "R8");
      chk(done && !fail, {tag, " R10 done"}, done, 1);
      chk(phase == idx[2:0], {tag, " R5 selected phase"}, phase, idx);
      chk(tuned_phase == idx[2:0], {tag, " R10 tuned"}, tuned_phase, idx);
      model_ph = idx[2:0];
      model_tuned = idx[2:0];
    end else begin
      chk(fail && !done, "R9 fail pulse", fail, 1);
      chk(phase == model_ph, "R9 phase restored", phase, model_ph);
      chk(tuned_phase == model_tuned, "R9 tuned kept", tuned_phase, model_tuned);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(phase == 0, "R1 phase", phase, 0);
    chk(tuned_phase == 0, "R1 tuned", tuned_phase, 0);
    chk(!trial_req && !tmo_force_max, "R1 req/tmo idle", trial_req, 0);
    chk(!done && !fail, "R1 done/fail idle", done, 0);
    // R11: start pulses while idle-gap are fine; chained starts cover R12
    for (int b = 0; b < 256; b++) begin
      int lat;
      lat = b % 3;
      // R12: odd maps start in the cycle that shows done/fail
      sweep(8'(b), lat, (b % 2 == 1), (b % 5 == 0) && lat > 0);
    end
    sweep(8'h00, 2, 1'b1, 1'b1);
    sweep(8'hFF, 1, 1'b1, 1'b0);
    sweep(8'b0011_1000, 0, 1'b1, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule